// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits between the command scheduler of an SDRAM controller and the memory pins. It has no effect on the data path. Its only job is to say whether a proposed command may go out on the current clock. The scheduler presents a candidate operation and a bank number. The guard answers in the same cycle with a single allow flag. Separately, the scheduler reports each command it actually issues and each cycle that carries the last beat of write data. The guard uses these reports to keep its counters.

Each bank has its own counters: clocks since its last ACTIVE, clocks since its last PRECHARGE, and clocks since its last write-data beat. A small shared unit tracks the spacing between ACTIVE commands to different banks and between column commands. Every limit given in nanoseconds is turned into a clock count at elaboration. The conversion divides by a clock-period parameter in picoseconds and rounds any fraction up. Two outputs per bank warn the scheduler before an open row reaches its maximum open time and report when that time has passed.

Top module: `sdram_timing_guard`

## Requirements
- R1: Each nanosecond limit is converted to a clock count as the ceiling of limit_ps / CLK_PS. With the defaults (CLK_PS=7500) this gives: row cycle 9, minimum row open 6, maximum row open 13334, precharge-to-activate 3, activate-to-column 3, bank-to-bank activate 2.
- R2: ACTIVE to a bank is allowed only if all of these hold: the bank is closed, at least the row-cycle count of clocks has passed since that bank's last ACTIVE, and at least the precharge-to-activate count has passed since its last PRECHARGE.
- R3: ACTIVE to any bank is refused until at least the bank-to-bank count of clocks has passed since the last ACTIVE to any bank.
- R4: READ or WRITE to a bank is allowed only if the bank is open and at least the activate-to-column count of clocks has passed since its ACTIVE. Column commands may follow one another every clock.
- R5: PRECHARGE to a bank is allowed only if all of these hold: the bank is open, at least the minimum row-open count has passed since its ACTIVE, and at least 2 clocks have passed since the last write-data beat to that bank. A beat in the current cycle counts as 0 clocks.
- R6: BURST STOP naming a bank is allowed only if the bank is open and at least 1 clock has passed since the last write-data beat to that bank. A beat in the current cycle counts as 0 clocks.
- R7: row_warn of a bank is high while the bank is open and at least (maximum row-open count − WARN_MARGIN) clocks have passed since its ACTIVE. row_late is high once the full maximum count has passed. Both drop in the clock after PRECHARGE.
- R8: Operation codes are NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, BURST STOP=5. NOP is always allowed. Codes 6 and 7 are never allowed.
- R9: After reset every bank is closed and every counter is saturated, so a first ACTIVE to any bank is allowed at once. No warning is raised.
- R10: A write-data beat reported for one bank has no effect on the PRECHARGE or BURST STOP checks of another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prop_op | input | 3 | Operation code of the proposed command |
| prop_bank | input | BANK_W | Bank of the proposed command |
| prop_ok | output | 1 | Proposed command meets every spacing rule this cycle |
| iss_valid | input | 1 | A command is issued this cycle |
| iss_op | input | 3 | Operation code of the issued command |
| iss_bank | input | BANK_W | Bank of the issued command |
| wd_last | input | 1 | Last write-data beat is on the bus this cycle |
| wd_bank | input | BANK_W | Bank that the last write-data beat belongs to |
| row_warn | output | NUM_BANKS | Per bank: open row is near its maximum open time |
| row_late | output | NUM_BANKS | Per bank: open row has exceeded its maximum open time |

## Verification
The assertions check rules that are local in time on every cycle. An issued ACTIVE blocks another ACTIVE in the next clock, both for the same bank and for any bank. A PRECHARGE clears the row's permissions and warning in the next clock. A same-cycle write beat always blocks BURST STOP. The late flag never appears without the warning. NOP and undefined codes give fixed answers. The exact boundaries of the multi-cycle windows can only be shown by the bench's scenarios. These include the clock at which a column command or PRECHARGE first becomes legal, and the clock at which ACTIVE becomes legal again after PRECHARGE. They also include the bank isolation of write recovery and the thousands-of-cycles path to the warning and late flags.

// File: rtl/sdram_guard_pkg.sv
`timescale 1ns/1ps
package sdram_guard_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_ACT   = 3'd1,
        OP_READ  = 3'd2,
        OP_WRITE = 3'd3,
        OP_PRE   = 3'd4,
        OP_BSTOP = 3'd5
    } guard_op_e;

    // Whole clocks needed to cover a limit; a partial clock counts as one.
    function automatic int ps_to_clk(input int limit_ps, input int clk_ps);
        return (limit_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int pick_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_bank_timer.sv
`timescale 1ns/1ps
module sdram_bank_timer #(
    parameter int RC_CLK      = 9,
    parameter int RAS_MIN_CLK = 6,
    parameter int RAS_MAX_CLK = 13334,
    parameter int RP_CLK      = 3,
    parameter int RCD_CLK     = 3,
    parameter int DPL_CLK     = 2,
    parameter int BDL_CLK     = 1,
    parameter int WARN_AT     = 13318
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic pre_i,
    input  logic wdl_i,
    output logic ok_act_o,
    output logic ok_rw_o,
    output logic ok_pre_o,
    output logic ok_bst_o,
    output logic warn_o,
    output logic late_o
);
    import sdram_guard_pkg::*;

    localparam int ACT_W = $clog2(RAS_MAX_CLK + 1);
    localparam int PRE_W = $clog2(RP_CLK + 1);
    localparam int WD_MAX = pick_max(DPL_CLK, BDL_CLK);
    localparam int WD_W  = $clog2(WD_MAX + 1);

    localparam logic [ACT_W-1:0] ACT_SAT  = ACT_W'(RAS_MAX_CLK);
    localparam logic [ACT_W-1:0] RC_V     = ACT_W'(RC_CLK);
    localparam logic [ACT_W-1:0] RASMIN_V = ACT_W'(RAS_MIN_CLK);
    localparam logic [ACT_W-1:0] RCD_V    = ACT_W'(RCD_CLK);
    localparam logic [ACT_W-1:0] WARN_V   = ACT_W'(WARN_AT);
    localparam logic [PRE_W-1:0] PRE_SAT  = PRE_W'(RP_CLK);
    localparam logic [WD_W-1:0]  WD_SAT   = WD_W'(WD_MAX);
    localparam logic [WD_W-1:0]  DPL_V    = WD_W'(DPL_CLK);
    localparam logic [WD_W-1:0]  BDL_V    = WD_W'(BDL_CLK);

    typedef struct packed {
        logic             open;
        logic [ACT_W-1:0] act_cnt;
        logic [PRE_W-1:0] pre_cnt;
        logic [WD_W-1:0]  wd_cnt;
    } bank_st_t;

    bank_st_t s_q, s_d;
    logic [WD_W-1:0] wd_eff;

    always_comb begin
        s_d = s_q;
        if (s_q.act_cnt != ACT_SAT) s_d.act_cnt = s_q.act_cnt + 1'b1;
        if (s_q.pre_cnt != PRE_SAT) s_d.pre_cnt = s_q.pre_cnt + 1'b1;
        if (s_q.wd_cnt  != WD_SAT)  s_d.wd_cnt  = s_q.wd_cnt + 1'b1;
        if (act_i) begin
            s_d.open    = 1'b1;
            s_d.act_cnt = ACT_W'(1);
        end
        if (pre_i) begin
            s_d.open    = 1'b0;
            s_d.pre_cnt = PRE_W'(1);
        end
        if (wdl_i) s_d.wd_cnt = WD_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.open    <= 1'b0;
            s_q.act_cnt <= ACT_SAT;
            s_q.pre_cnt <= PRE_SAT;
            s_q.wd_cnt  <= WD_SAT;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        wd_eff   = wdl_i ? '0 : s_q.wd_cnt;
        ok_act_o = !s_q.open && (s_q.act_cnt >= RC_V) && (s_q.pre_cnt >= PRE_SAT);
        ok_rw_o  = s_q.open && (s_q.act_cnt >= RCD_V);
        ok_pre_o = s_q.open && (s_q.act_cnt >= RASMIN_V) && (wd_eff >= DPL_V);
        ok_bst_o = s_q.open && (wd_eff >= BDL_V);
        warn_o   = s_q.open && (s_q.act_cnt >= WARN_V);
        late_o   = s_q.open && (s_q.act_cnt == ACT_SAT);
    end

    p_act_blocks_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> !ok_act_o);

    p_pre_closes_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i && !act_i |=> (!ok_pre_o && !ok_rw_o && !ok_bst_o));

    p_pre_clears_warn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i && !act_i |=> (!warn_o && !late_o));

    p_late_has_warn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        late_o |-> warn_o);

    generate
        if (BDL_CLK > 0) begin : g_bdl_chk
            p_beat_blocks_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
                wdl_i |-> !ok_bst_o);
        end
    endgenerate

endmodule

// File: rtl/sdram_shared_spacing.sv
`timescale 1ns/1ps
module sdram_shared_spacing #(
    parameter int RRD_CLK = 2,
    parameter int CCD_CLK = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic rw_i,
    output logic ok_act_o,
    output logic ok_rw_o
);
    localparam int AG_W = $clog2(RRD_CLK + 1);
    localparam int RW_W = $clog2(CCD_CLK + 1);
    localparam logic [AG_W-1:0] AG_SAT = AG_W'(RRD_CLK);
    localparam logic [RW_W-1:0] RW_SAT = RW_W'(CCD_CLK);

    typedef struct packed {
        logic [AG_W-1:0] act_gap;
        logic [RW_W-1:0] rw_gap;
    } shared_st_t;

    shared_st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (s_q.act_gap != AG_SAT) s_d.act_gap = s_q.act_gap + 1'b1;
        if (s_q.rw_gap  != RW_SAT) s_d.rw_gap  = s_q.rw_gap + 1'b1;
        if (act_i) s_d.act_gap = AG_W'(1);
        if (rw_i)  s_d.rw_gap  = RW_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.act_gap <= AG_SAT;
            s_q.rw_gap  <= RW_SAT;
        end else begin
            s_q <= s_d;
        end
    end

    assign ok_act_o = (s_q.act_gap == AG_SAT);
    assign ok_rw_o  = (s_q.rw_gap == RW_SAT);

    generate
        if (RRD_CLK > 1) begin : g_rrd_chk
            p_act_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
                act_i |=> !ok_act_o);
        end
    endgenerate

endmodule

// File: rtl/sdram_timing_guard.sv
`timescale 1ns/1ps
module sdram_timing_guard
    import sdram_guard_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int CLK_PS       = 7500,
    parameter int T_RC_PS      = 67500,
    parameter int T_RAS_MIN_PS = 45000,
    parameter int T_RAS_MAX_PS = 100000000,
    parameter int T_RP_PS      = 22500,
    parameter int T_RCD_PS     = 22500,
    parameter int T_RRD_PS     = 15000,
    parameter int CCD_CLK      = 1,
    parameter int DPL_CLK      = 2,
    parameter int BDL_CLK      = 1,
    parameter int WARN_MARGIN  = 16,
    localparam int BANK_W      = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           prop_op,
    input  logic [BANK_W-1:0]    prop_bank,
    output logic                 prop_ok,
    input  logic                 iss_valid,
    input  logic [2:0]           iss_op,
    input  logic [BANK_W-1:0]    iss_bank,
    input  logic                 wd_last,
    input  logic [BANK_W-1:0]    wd_bank,
    output logic [NUM_BANKS-1:0] row_warn,
    output logic [NUM_BANKS-1:0] row_late
);
    localparam int RC_CLK      = ps_to_clk(T_RC_PS, CLK_PS);
    localparam int RAS_MIN_CLK = ps_to_clk(T_RAS_MIN_PS, CLK_PS);
    localparam int RAS_MAX_CLK = ps_to_clk(T_RAS_MAX_PS, CLK_PS);
    localparam int RP_CLK      = ps_to_clk(T_RP_PS, CLK_PS);
    localparam int RCD_CLK     = ps_to_clk(T_RCD_PS, CLK_PS);
    localparam int RRD_CLK     = ps_to_clk(T_RRD_PS, CLK_PS);
    localparam int WARN_AT     = (RAS_MAX_CLK > WARN_MARGIN) ? RAS_MAX_CLK - WARN_MARGIN : 1;

    logic [NUM_BANKS-1:0] b_act, b_pre, b_wdl;
    logic [NUM_BANKS-1:0] b_ok_act, b_ok_rw, b_ok_pre, b_ok_bst;
    logic                 any_act, any_rw;
    logic                 sh_ok_act, sh_ok_rw;

    assign any_act = iss_valid && (iss_op == OP_ACT);
    assign any_rw  = iss_valid && ((iss_op == OP_READ) || (iss_op == OP_WRITE));

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign b_act[b] = any_act && (iss_bank == BANK_W'(b));
            assign b_pre[b] = iss_valid && (iss_op == OP_PRE) && (iss_bank == BANK_W'(b));
            assign b_wdl[b] = wd_last && (wd_bank == BANK_W'(b));

            sdram_bank_timer #(
                .RC_CLK      (RC_CLK),
                .RAS_MIN_CLK (RAS_MIN_CLK),
                .RAS_MAX_CLK (RAS_MAX_CLK),
                .RP_CLK      (RP_CLK),
                .RCD_CLK     (RCD_CLK),
                .DPL_CLK     (DPL_CLK),
                .BDL_CLK     (BDL_CLK),
                .WARN_AT     (WARN_AT)
            ) i_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .act_i    (b_act[b]),
                .pre_i    (b_pre[b]),
                .wdl_i    (b_wdl[b]),
                .ok_act_o (b_ok_act[b]),
                .ok_rw_o  (b_ok_rw[b]),
                .ok_pre_o (b_ok_pre[b]),
                .ok_bst_o (b_ok_bst[b]),
                .warn_o   (row_warn[b]),
                .late_o   (row_late[b])
            );
        end
    endgenerate

    sdram_shared_spacing #(
        .RRD_CLK (RRD_CLK),
        .CCD_CLK (CCD_CLK)
    ) i_shared (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (any_act),
        .rw_i     (any_rw),
        .ok_act_o (sh_ok_act),
        .ok_rw_o  (sh_ok_rw)
    );

    always_comb begin
        case (prop_op)
            OP_NOP:            prop_ok = 1'b1;
            OP_ACT:            prop_ok = b_ok_act[prop_bank] && sh_ok_act;
            OP_READ, OP_WRITE: prop_ok = b_ok_rw[prop_bank] && sh_ok_rw;
            OP_PRE:            prop_ok = b_ok_pre[prop_bank];
            OP_BSTOP:          prop_ok = b_ok_bst[prop_bank];
            default:           prop_ok = 1'b0;
        endcase
    end

    p_nop_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_op == 3'd0) |-> prop_ok);

    p_undef_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_op > 3'd5) |-> !prop_ok);

    p_act_any_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (any_act && RRD_CLK > 1) |=> !(prop_op == 3'd1 && prop_ok));

endmodule

// File: tb/test_sdram_timing_guard.sv
`timescale 1ns/1ps
module test_sdram_timing_guard;

    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                           C_PRE = 3'd4, C_BST = 3'd5;
    localparam int CLKP = 7500;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // R1: expected clock counts derived independently
    localparam int E_RAS_MAX = cdiv(100000000, CLKP);   // 13334
    localparam int E_WARN    = E_RAS_MAX - 16;          // 13318

    logic       clk = 0;
    logic       rst_n = 0;
    logic [2:0] prop_op = 0;
    logic [1:0] prop_bank = 0;
    logic       prop_ok;
    logic       iss_valid = 0;
    logic [2:0] iss_op = 0;
    logic [1:0] iss_bank = 0;
    logic       wd_last = 0;
    logic [1:0] wd_bank = 0;
    logic [3:0] row_warn, row_late;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    sdram_timing_guard i_sdram_timing_guard (
        .clk(clk), .rst_n(rst_n),
        .prop_op(prop_op), .prop_bank(prop_bank), .prop_ok(prop_ok),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_bank(iss_bank),
        .wd_last(wd_last), .wd_bank(wd_bank),
        .row_warn(row_warn), .row_late(row_late)
    );

    // Monitor: compares the allow flag with the queued expectation mid-cycle.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (prop_ok !== e) begin
                errors++;
                $display("FAIL %s: prop_ok=%0b expected %0b", t, prop_ok, e);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
        iss_valid = 0;
        wd_last   = 0;
        prop_op   = C_NOP;
        prop_bank = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic probe(input logic [2:0] op, input int bank, input bit e, input string t);
        prop_op   = op;
        prop_bank = bank[1:0];
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic issue(input logic [2:0] op, input int bank);
        iss_valid = 1;
        iss_op    = op;
        iss_bank  = bank[1:0];
    endtask

    task automatic beat(input int bank);
        wd_last = 1;
        wd_bank = bank[1:0];
    endtask

    task automatic chk_row(input int bank, input bit ew, input bit el, input string t);
        @(negedge clk);
        checks++;
        if (row_warn[bank] !== ew || row_late[bank] !== el) begin
            errors++;
            $display("FAIL %s: warn=%0b late=%0b expected warn=%0b late=%0b",
                     t, row_warn[bank], row_late[bank], ew, el);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // ---- R9 / R8: state after reset
        probe(C_ACT, 0, 1, "R9 first ACT allowed"); cyc();
        probe(C_RD, 0, 0, "R4 READ on closed bank"); cyc();
        probe(C_PRE, 0, 0, "R5 PRE on closed bank"); cyc();
        probe(C_NOP, 0, 1, "R8 NOP always allowed"); cyc();
        probe(3'd7, 2, 0, "R8 undefined code"); chk_row(0, 0, 0, "R9 no warning after reset"); cyc();

        // ---- activate spacing, column delay, row minimum (cycle c0 = ACT b0)
        probe(C_ACT, 0, 1, "R2 ACT b0"); issue(C_ACT, 0); cyc();       // c0
        probe(C_ACT, 1, 0, "R3 ACT b1 one clock after ACT b0"); cyc(); // c1
        probe(C_RD, 0, 0, "R4 READ before RCD"); cyc();                // c2
        probe(C_WR, 0, 1, "R4 WRITE at RCD"); issue(C_WR, 0); cyc();   // c3
        probe(C_ACT, 1, 1, "R3 ACT b1 after gap"); issue(C_ACT, 1); cyc(); // c4
        probe(C_PRE, 0, 0, "R5 PRE before row minimum"); cyc();        // c5
        probe(C_PRE, 0, 1, "R5 PRE at row minimum"); issue(C_PRE, 0); cyc(); // c6
        probe(C_ACT, 1, 0, "R2 ACT on open bank"); cyc();              // c7
        probe(C_ACT, 0, 0, "R2 ACT before precharge recovery"); cyc(); // c8
        probe(C_ACT, 0, 1, "R2 ACT at row cycle"); cyc();              // c9

        // ---- write recovery on bank 1 (opened at c4)
        probe(C_BST, 1, 0, "R6 STOP with same-cycle beat"); beat(1); cyc(); // c10
        probe(C_PRE, 1, 0, "R5 PRE one clock after beat"); cyc();          // c11
        probe(C_PRE, 1, 1, "R10 PRE b1 with beat on b0"); beat(0); issue(C_PRE, 1); cyc(); // c12
        probe(C_BST, 1, 0, "R6 STOP on closed bank"); cyc();               // c13

        idle(5);
        // ---- column commands back to back
        probe(C_ACT, 2, 1, "R2 ACT b2"); issue(C_ACT, 2); cyc();
        idle(2);
        probe(C_RD, 2, 1, "R4 READ b2"); issue(C_RD, 2); cyc();
        probe(C_WR, 2, 1, "R4 WRITE next clock"); issue(C_WR, 2); cyc();
        probe(C_BST, 2, 1, "R6 STOP with no recent beat"); cyc();
        idle(3);
        probe(C_PRE, 2, 1, "R5 PRE b2"); issue(C_PRE, 2); cyc();

        idle(10);
        // ---- precharge recovery on bank 3 where RP dominates
        probe(C_ACT, 3, 1, "R2 ACT b3"); issue(C_ACT, 3); cyc();     // d0
        idle(6);
        probe(C_PRE, 3, 1, "R5 PRE b3"); issue(C_PRE, 3); cyc();     // d7
        cyc();                                                        // d8
        probe(C_ACT, 3, 0, "R2 ACT two clocks after PRE"); cyc();    // d9
        probe(C_ACT, 3, 1, "R2 ACT three clocks after PRE"); cyc();  // d10

        idle(5);
        // ---- maximum row open time on bank 2
        probe(C_ACT, 2, 1, "R7 ACT b2 for long row"); issue(C_ACT, 2); cyc();
        idle(E_WARN - 2);
        chk_row(2, 0, 0, "R7 one clock before warning");
        cyc();
        chk_row(2, 1, 0, "R7 warning threshold");
        idle(E_RAS_MAX - E_WARN - 1);
        chk_row(2, 1, 0, "R7 one clock before late");
        cyc();
        chk_row(2, 1, 1, "R7 late at maximum");
        probe(C_PRE, 2, 1, "R7 PRE of late row"); issue(C_PRE, 2); cyc();
        chk_row(2, 0, 0, "R7 flags clear after PRE");
        cyc();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule